// File: doc/BRIEF.md
# Sparse Hit Serialiser with Look-Ahead Token

This block reads out a two-dimensional pixel array and sends only the pixels that matter. A start strobe captures the per-pixel hit flags, the per-pixel timestamps and a read-all control. A token then walks the array row by row, lowest column first. It skips pixels that hold no hit. Each selected pixel becomes one 30-bit word on a single serial line, one bit per clock.

The token examines one pixel per clock. It runs ahead of the serialiser and parks the next word in a one-entry holding register while the current word is still going out, so a new word can follow the previous one with no idle bit between them. The row address comes from a single counter that moves on when the token leaves the last column. Column 0 is always emitted, so every row produces at least one word and the receiver can see each row boundary. After the final word of the last row has gone out, a done flag rises and stays high until the next start.

Top module: `hit_token_reader`

## Requirements
- R1: While reset is asserted and after it is released with no start, `svalid` and `done` are low.
- R2: Each word is 30 bits, sent MSB first while `svalid` is high, laid out as header[29:25], X[24:15], Y[14:5], timestamp[4:0]. The header is 5'b11111 for a pixel whose hit flag was set and 5'b10000 for a pixel that is emitted without a hit.
- R3: Words come out in scan order: rows in ascending Y, and columns in ascending X inside a row. A pixel in columns 1 and up is emitted only if its hit flag was set or read-all was active.
- R4: The pixel in column 0 of every row is always emitted, so each row yields at least one word.
- R5: The X field holds the pixel's column index and the Y field holds its row index, both zero-extended to 10 bits.
- R6: The timestamp field holds the 5-bit timestamp of the emitted pixel.
- R7: When `read_all` is high at start, every pixel of the array is emitted. The header still reports the pixel's own hit flag.
- R8: The hit flags, timestamps and `read_all` are captured on the start strobe. Changes after that strobe have no effect on the readout in progress.
- R9: A start strobe that arrives while a readout is in progress is ignored.
- R10: Look-ahead: from the first bit of the first word to the last bit of the last word, `svalid` stays high without a gap whenever the next pixel is found before the current word ends.
- R11: `done` rises only after the last word has been fully shifted out. It is never high together with `svalid`, it stays high until the next start, and it falls on the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a readout; captures the array inputs |
| read_all | input | 1 | Treat every pixel as selected |
| hit_map | input | COLS*ROWS | Hit flags, pixel index y*COLS+x |
| ts_map | input | COLS*ROWS*TSW | Timestamps, TSW bits per pixel at the same index |
| sdata | output | 1 | Serial word bit, MSB first |
| svalid | output | 1 | High while `sdata` carries a word bit |
| done | output | 1 | Readout complete |

## Verification
On every cycle the assertions check that a started word keeps `svalid` high for all 30 of its bits, that each word opens with a set header MSB, that `done` never overlaps `svalid`, and that `done` holds until the next start and falls after it. Scan order, skipping, the forced column 0, the address and timestamp fields, the read-all effect and the capture at start all depend on the content of the array. The bench's scenarios cover these by comparing every received word with a queue built from the input map. The gapless look-ahead stream and the ignored second start are shown only by those scenarios.

// File: rtl/hit_token_reader.sv
module hit_token_reader #(
  parameter int COLS = 8,
  parameter int ROWS = 4,
  parameter int AW   = 10,
  parameter int TSW  = 5,
  parameter int HDRW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      read_all,
  input  logic [COLS*ROWS-1:0]      hit_map,
  input  logic [COLS*ROWS*TSW-1:0]  ts_map,
  output logic                      sdata,
  output logic                      svalid,
  output logic                      done
);
  localparam int NPIX  = COLS * ROWS;
  localparam int WORDW = HDRW + 2 * AW + TSW;
  localparam int XW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int YW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int PW    = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int CW    = $clog2(WORDW + 1);
  localparam logic [HDRW-1:0] HDR_HIT    = '1;
  localparam logic [HDRW-1:0] HDR_FORCED = {1'b1, {(HDRW-1){1'b0}}};

  logic                running, scan_on, all_l, nxt_full;
  logic [NPIX-1:0]     snap;
  logic [NPIX*TSW-1:0] ts_l;
  logic [XW-1:0]       sx;
  logic [YW-1:0]       sy;
  logic [WORDW-1:0]    nxt, shreg;
  logic [CW-1:0]       cnt;

  logic [PW-1:0]    pidx;
  logic             pix_hit, cand, col_end, scan_step, take;
  logic [TSW-1:0]   pix_ts;
  logic [WORDW-1:0] word;

  assign pidx      = PW'(sy) * PW'(COLS) + PW'(sx);
  assign pix_hit   = snap[pidx];
  assign pix_ts    = ts_l[pidx*TSW +: TSW];
  assign cand      = pix_hit | all_l | (sx == '0);
  assign word      = {pix_hit ? HDR_HIT : HDR_FORCED, AW'(sx), AW'(sy), pix_ts};
  assign col_end   = (sx == XW'(COLS - 1));
  assign scan_step = scan_on && !nxt_full;
  assign take      = nxt_full && (cnt <= CW'(1));

  assign sdata  = shreg[WORDW-1];
  assign svalid = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      scan_on  <= 1'b0;
      all_l    <= 1'b0;
      nxt_full <= 1'b0;
      snap     <= '0;
      ts_l     <= '0;
      sx       <= '0;
      sy       <= '0;
      nxt      <= '0;
      shreg    <= '0;
      cnt      <= '0;
      done     <= 1'b0;
    end else if (start && !running) begin
      running  <= 1'b1;
      scan_on  <= 1'b1;
      all_l    <= read_all;
      nxt_full <= 1'b0;
      snap     <= hit_map;
      ts_l     <= ts_map;
      sx       <= '0;
      sy       <= '0;
      cnt      <= '0;
      done     <= 1'b0;
    end else if (running) begin
      if (scan_step) begin
        if (cand) begin
          nxt      <= word;
          nxt_full <= 1'b1;
        end
        if (col_end) begin
          sx <= '0;
          if (sy == YW'(ROWS - 1)) scan_on <= 1'b0;
          else                     sy <= sy + 1'b1;
        end else begin
          sx <= sx + 1'b1;
        end
      end
      if (take) begin
        shreg    <= nxt;
        cnt      <= CW'(WORDW);
        nxt_full <= 1'b0;
      end else if (cnt != '0) begin
        shreg <= shreg << 1;
        cnt   <= cnt - 1'b1;
      end
      if (!scan_on && !nxt_full && cnt == '0) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_token_reader_chk.sv
module hit_token_reader_chk #(
  parameter int WORDW = 30
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sdata,
  input logic svalid,
  input logic done
);
  localparam int BW = $clog2(WORDW + 1);
  logic [BW-1:0] bitpos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bitpos <= '0;
    else if (svalid) bitpos <= (bitpos == BW'(WORDW - 1)) ? '0 : bitpos + 1'b1;
  end

  assert_word_unbroken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bitpos != '0) |-> svalid);

  assert_header_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (svalid && bitpos == '0) |-> sdata);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !svalid);

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);
endmodule

bind hit_token_reader hit_token_reader_chk #(.WORDW(WORDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sdata(sdata), .svalid(svalid), .done(done)
);

// File: tb/test_hit_token_reader.sv
module test_hit_token_reader;
  localparam int COLS = 8, ROWS = 4, TSW = 5, NPIX = COLS * ROWS, WORDW = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, read_all = 1'b0;
  logic [NPIX-1:0]     hit_map = '0;
  logic [NPIX*TSW-1:0] ts_map = '0;
  logic sdata, svalid, done;

  always #10 clk = ~clk;

  hit_token_reader i_hit_token_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .read_all(read_all),
    .hit_map(hit_map), .ts_map(ts_map),
    .sdata(sdata), .svalid(svalid), .done(done)
  );

  int tests = 0, fails = 0;
  logic [WORDW-1:0] exp_q[$];
  int cyc = 0, first_v = -1, last_v = -1, vcount = 0, words_seen = 0;
  logic [WORDW-1:0] acc = '0;
  int bitn = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (svalid === 1'b1) begin
      if (first_v < 0) first_v = cyc;
      last_v = cyc;
      vcount++;
      acc = {acc[WORDW-2:0], sdata};
      bitn++;
      if (bitn == WORDW) begin
        bitn = 0;
        words_seen++;
        if (exp_q.size() == 0) check("R3 unexpected word", 64'(acc), 64'h0);
        else check("R2/R3/R4/R5/R6 word", 64'(acc), 64'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [NPIX*TSW-1:0] make_ts(input int seed);
    logic [NPIX*TSW-1:0] t;
    for (int p = 0; p < NPIX; p++) t[p*TSW +: TSW] = TSW'(p * 7 + seed);
    return t;
  endfunction

  task automatic push_expected(input logic [NPIX-1:0] hm, input logic [NPIX*TSW-1:0] ts, input logic ra);
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++) begin
        logic h;
        h = hm[y*COLS + x];
        if (h || ra || x == 0)
          exp_q.push_back({h ? 5'b11111 : 5'b10000, 10'(x), 10'(y), ts[(y*COLS+x)*TSW +: TSW]});
      end
  endtask

  task automatic run_case(input string name, input logic [NPIX-1:0] hm,
                          input logic [NPIX*TSW-1:0] ts, input logic ra,
                          input bit disturb, input bit restart);
    int nwords, waited;
    hit_map = hm; ts_map = ts; read_all = ra;
    exp_q.delete();
    push_expected(hm, ts, ra);
    nwords = exp_q.size();
    first_v = -1; last_v = -1; vcount = 0; words_seen = 0; bitn = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({name, " R11 done falls after start"}, 64'(done), 64'd0);
    if (disturb) begin
      hit_map = ~hm; ts_map = ~ts; read_all = ~ra;   // R8: must be ignored
    end
    if (restart) begin
      repeat (40) @(negedge clk);
      hit_map = '1; read_all = 1'b1;                // R9: start mid readout ignored
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (done !== 1'b1 && waited < 20000) begin
      @(negedge clk); waited++;
    end
    check({name, " R11 done reached"}, 64'(done), 64'd1);
    check({name, " R3 all words received"}, 64'(exp_q.size()), 64'd0);
    check({name, " R10 valid bit count"}, 64'(vcount), 64'(nwords * WORDW));
    check({name, " R10 gapless stream"}, 64'(last_v - first_v + 1), 64'(vcount));
    repeat (3) @(negedge clk);
    check({name, " R11 done holds"}, 64'(done), 64'd1);
    check({name, " R11 no valid after done"}, 64'(svalid), 64'd0);
  endtask

  initial begin
    logic [NPIX-1:0] sparse;
    repeat (3) @(negedge clk);
    check("R1 svalid in reset", 64'(svalid), 64'd0);
    check("R1 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 svalid idle", 64'(svalid), 64'd0);
    check("R1 done idle", 64'(done), 64'd0);

    run_case("empty R4", '0, make_ts(3), 1'b0, 0, 0);
    sparse = '0;
    sparse[0] = 1'b1; sparse[5] = 1'b1; sparse[7] = 1'b1;
    sparse[2*COLS + 3] = 1'b1; sparse[3*COLS + 7] = 1'b1;
    run_case("sparse R3 R5 R6", sparse, make_ts(11), 1'b0, 0, 0);
    run_case("full R10", '1, make_ts(1), 1'b0, 0, 0);
    run_case("readall R7", sparse, make_ts(5), 1'b1, 0, 0);
    run_case("capture R8", sparse, make_ts(9), 1'b0, 1, 0);
    run_case("restart R9", sparse, make_ts(13), 1'b0, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule